// File: doc/BRIEF.md
# Embedded CPU Boot Memory Loader Port

This block sits between a host-facing 32-bit register port and a small embedded processor. It lets the host halt the processor, fill its byte-wide program memory, read that memory back to confirm the image, and then let the processor run again. The host does all of this through a handful of registers: a processor control word, a program-memory address pointer, a one-byte data window into the memory, a mailbox word, a clock-delay setting and a read-only identification word.

A typical boot runs in this order. The host writes the halt value to the control word, which holds the processor in reset and opens the data window. It writes 0 to the pointer and then writes the image one byte per access to the window; the pointer advances after every access. It rewinds the pointer and reads the image back the same way. Last, it writes the run value to the control word. The program memory is internal and its depth is a parameter that must be a power of two. The processor itself is outside the block.

Top module: `bl_boot_port`

## Requirements
- R1: After reset the control word, pointer, mailbox and clock-delay setting are 0, `reg_rdata` is 0, and all three processor outputs are low.
- R2: The control word keeps only bits 8, 7, 3, 2, 1 and 0 of a write to offset 0x10. All other bits read back as 0.
- R3: `cpu_clk_en` follows control bit 1 and `cpu_boot_en` follows control bit 3. `cpu_soft_rst` is high when control bit 0 or control bit 7 (reset hold) is set.
- R4: A write to offset 0x11 loads the pointer with the low log2(depth) bits of the write data, so writing 0 rewinds it. A read of 0x11 returns the pointer, zero-extended.
- R5: While control bit 2 (external access) is set, a write to offset 0x12 stores write-data bits [7:0] at the pointer and then advances the pointer by one.
- R6: While control bit 2 is set, a read of offset 0x12 returns the byte at the pointer in bits [7:0], with bits [31:8] zero, and then advances the pointer by one.
- R7: When the pointer advances from the last location (depth-1), it goes to 0.
- R8: While control bit 2 is clear, writes to 0x12 leave the memory unchanged, reads of 0x12 return 0, and neither kind of access moves the pointer.
- R9: Offset 0x18 reads as {revision[3:0], device code[15:0], 12'h000}, and both fields are parameters.
- R10: Offset 0x05 (clock delay) keeps bits [5:4] and [1:0] of a write and reads them back unchanged. Its other bits read as 0.
- R11: Offset 0x15 (mailbox) is a full 32-bit register that can be written and read.
- R12: Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read. Offsets that are not mapped read as 0.
- R13: When the write and read strobes are high in the same cycle, only the write takes place: `reg_rdata` keeps its value and a window access advances the pointer only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe, one access per cycle |
| reg_rdata | output | 32 | Registered read data |
| cpu_soft_rst | output | 1 | Reset to the embedded processor |
| cpu_clk_en | output | 1 | Clock enable to the embedded processor |
| cpu_boot_en | output | 1 | Boot enable to the embedded processor |

## Verification
The hardest case to reach is the pointer wrap. A step from the last memory location to location 0 happens only after a full pass of window accesses with no reload of the pointer in between. The bench therefore builds the block with a 16-byte memory. It streams a full image through the window, reads the pointer back to confirm it returned to 0, and then makes one more read after a complete read-back pass to confirm it lands on byte 0. Gated window accesses, and accesses where both strobes are high, are placed in the middle of a loaded image. Any stray store or pointer step then shows up as a wrong byte or a wrong pointer value.

// File: rtl/bl_boot_pkg.sv
package bl_boot_pkg;
  // register offsets (host-visible map)
  localparam logic [7:0] OFS_CLKDLY = 8'h05;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_PTR    = 8'h11;
  localparam logic [7:0] OFS_WIN    = 8'h12;
  localparam logic [7:0] OFS_MBOX   = 8'h15;
  localparam logic [7:0] OFS_ID     = 8'h18;

  // control word bit positions
  localparam int CB_CLKDIV = 8;
  localparam int CB_HOLD   = 7;
  localparam int CB_BOOT   = 3;
  localparam int CB_EXT    = 2;
  localparam int CB_CLKEN  = 1;
  localparam int CB_SRST   = 0;

  localparam logic [31:0] CTRL_MASK   = 32'h0000_018F;
  localparam logic [31:0] CLKDLY_MASK = 32'h0000_0033;
endpackage

// File: rtl/bl_ctrl_regs.sv
module bl_ctrl_regs
  import bl_boot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_dly,
  input  logic        wr_mbox,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q,
  output logic [31:0] dly_q,
  output logic [31:0] mbox_q,
  output logic        ext_acc,
  output logic        cpu_soft_rst,
  output logic        cpu_clk_en,
  output logic        cpu_boot_en
);
  logic [31:0] ctrl_d, dly_d, mbox_d;

  always_comb begin
    ctrl_d = ctrl_q;
    dly_d  = dly_q;
    mbox_d = mbox_q;
    if (wr_ctrl) ctrl_d = wdata & CTRL_MASK;
    if (wr_dly)  dly_d  = wdata & CLKDLY_MASK;
    if (wr_mbox) mbox_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dly_q  <= '0;
      mbox_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dly_q  <= dly_d;
      mbox_q <= mbox_d;
    end
  end

  assign ext_acc      = ctrl_q[CB_EXT];
  assign cpu_clk_en   = ctrl_q[CB_CLKEN];
  assign cpu_boot_en  = ctrl_q[CB_BOOT];
  assign cpu_soft_rst = ctrl_q[CB_SRST] | ctrl_q[CB_HOLD];

  assert_ctrl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == ($past(wdata) & CTRL_MASK));
  assert_hold_forces_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CB_HOLD]) |=> cpu_soft_rst);
  assert_dly_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dly |=> dly_q == ($past(wdata) & CLKDLY_MASK));
endmodule

// File: rtl/bl_prog_mem.sv
module bl_prog_mem #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_acc,
  input  logic          ptr_ld,
  input  logic [31:0]   ptr_val,
  input  logic          win_wr,
  input  logic          win_rd,
  input  logic [7:0]    wbyte,
  output logic [AW-1:0] ptr_q,
  output logic [7:0]    rbyte_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr_d;
  logic [7:0]    rbyte_d;
  logic          do_wr, do_rd, step;

  always_comb begin
    do_wr   = win_wr & ext_acc;
    do_rd   = win_rd & ext_acc;
    step    = do_wr | do_rd;
    rbyte_d = rbyte_q;
    ptr_d   = ptr_q;
    if (do_rd) rbyte_d = mem[ptr_q];
    if (ptr_ld)
      ptr_d = ptr_val[AW-1:0];
    else if (step)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rbyte_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      rbyte_q <= rbyte_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_wr) mem[ptr_q] <= wbyte;
  end

  assert_ptr_step_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_wr || win_rd) && ext_acc && !ptr_ld) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_wr || win_rd) && !ext_acc && !ptr_ld) |=> $stable(ptr_q));
  assert_ptr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_q == $past(ptr_val[AW-1:0]));
endmodule

// File: rtl/bl_boot_port.sv
module bl_boot_port
  import bl_boot_pkg::*;
#(
  parameter int          MEM_DEPTH   = 2048,
  parameter logic [15:0] DEVICE_CODE = 16'h5A3C,
  parameter logic [3:0]  REVISION    = 4'h2,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        cpu_soft_rst,
  output logic        cpu_clk_en,
  output logic        cpu_boot_en
);
  localparam logic [31:0] ID_WORD = {REVISION, DEVICE_CODE, 12'h000};

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic hit_ctrl, hit_dly, hit_mbox, hit_ptr, hit_win, hit_id, any_hit;
  logic rd_go;
  always_comb begin
    hit_ctrl = (reg_addr == OFS_CTRL);
    hit_dly  = (reg_addr == OFS_CLKDLY);
    hit_mbox = (reg_addr == OFS_MBOX);
    hit_ptr  = (reg_addr == OFS_PTR);
    hit_win  = (reg_addr == OFS_WIN);
    hit_id   = (reg_addr == OFS_ID);
    any_hit  = hit_ctrl | hit_dly | hit_mbox | hit_ptr | hit_win | hit_id;
    rd_go    = reg_rd & ~reg_wr;
  end

  logic [31:0]   ctrl_q, dly_q, mbox_q;
  logic          ext_acc;
  logic [AW-1:0] ptr_q;
  logic [7:0]    rbyte_q;

  bl_ctrl_regs u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .wr_ctrl      (reg_wr & hit_ctrl),
    .wr_dly       (reg_wr & hit_dly),
    .wr_mbox      (reg_wr & hit_mbox),
    .wdata        (reg_wdata),
    .ctrl_q       (ctrl_q),
    .dly_q        (dly_q),
    .mbox_q       (mbox_q),
    .ext_acc      (ext_acc),
    .cpu_soft_rst (cpu_soft_rst),
    .cpu_clk_en   (cpu_clk_en),
    .cpu_boot_en  (cpu_boot_en)
  );

  bl_prog_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ext_acc (ext_acc),
    .ptr_ld  (reg_wr & hit_ptr),
    .ptr_val (reg_wdata),
    .win_wr  (reg_wr & hit_win),
    .win_rd  (rd_go & hit_win),
    .wbyte   (reg_wdata[7:0]),
    .ptr_q   (ptr_q),
    .rbyte_q (rbyte_q)
  );

  // read path: register word and memory-select flag
  logic [31:0] rword_d, rword_q;
  logic        sel_mem_d, sel_mem_q;
  always_comb begin
    rword_d   = rword_q;
    sel_mem_d = sel_mem_q;
    if (rd_go) begin
      sel_mem_d = hit_win & ext_acc;
      unique case (1'b1)
        hit_ctrl: rword_d = ctrl_q;
        hit_dly:  rword_d = dly_q;
        hit_mbox: rword_d = mbox_q;
        hit_ptr:  rword_d = 32'(ptr_q);
        hit_id:   rword_d = ID_WORD;
        default:  rword_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rword_q   <= '0;
      sel_mem_q <= 1'b0;
    end else begin
      rword_q   <= rword_d;
      sel_mem_q <= sel_mem_d;
    end
  end

  assign reg_rdata = sel_mem_q ? {24'h0, rbyte_q} : rword_q;

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_go && !any_hit) |=> reg_rdata == 32'h0);
  assert_win_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_go && hit_win) |=> reg_rdata[31:8] == 24'h0);
  assert_both_strobes_R13: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && reg_rd) |=> $stable(reg_rdata));
endmodule

// File: tb/tb_bl_boot_port.sv
module tb_bl_boot_port;
  localparam int DEPTH = 16;
  localparam logic [31:0] ID_EXP = 32'h9C0D_E000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        cpu_soft_rst, cpu_clk_en, cpu_boot_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  bl_boot_port #(.MEM_DEPTH(DEPTH), .DEVICE_CODE(16'hC0DE), .REVISION(4'h9)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cpu_soft_rst(cpu_soft_rst), .cpu_clk_en(cpu_clk_en), .cpu_boot_en(cpu_boot_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog: act=%0d exp<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 outs", {29'h0, cpu_soft_rst, cpu_clk_en, cpu_boot_en}, 32'h0);
    rd(8'h11, v); chk("R1 ptr", v, 32'h0);
    rd(8'h10, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h15, v); chk("R1 mbox", v, 32'h0);
    rd(8'h05, v); chk("R1 dly", v, 32'h0);

    // R2/R3 sweep of all control bit combinations
    for (int c = 0; c < 512; c++) begin
      w = 32'(c) ^ 32'hFFFF_FE70;
      wr(8'h10, w);
      chk("R3 clk_en", {31'h0, cpu_clk_en}, {31'h0, w[1]});
      chk("R3 boot_en", {31'h0, cpu_boot_en}, {31'h0, w[3]});
      chk("R3 soft_rst", {31'h0, cpu_soft_rst}, {31'h0, w[0] | w[7]});
      rd(8'h10, v);
      chk("R2 ctrl readback", v, w & 32'h18F);
    end

    // halt value: hold, boot, external access
    wr(8'h10, 32'h0000_008C);
    chk("R3 halt soft_rst", {31'h0, cpu_soft_rst}, 32'h1);

    // R5/R7 full image load
    wr(8'h11, 32'h0);
    for (int i = 0; i < DEPTH; i++) wr(8'h12, {24'hABCDEF, pat(i, 1)});
    rd(8'h11, v); chk("R7 ptr wrap after write pass", v, 32'h0);

    // R4 load uses low bits, readback
    wr(8'h11, 32'h0000_0023);
    rd(8'h11, v); chk("R4 ptr load", v, 32'h3);
    wr(8'h11, 32'h0);
    rd(8'h11, v); chk("R4 ptr rewind", v, 32'h0);

    // R6 read-back pass
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h12, v);
      chk("R6 window read", v, {24'h0, pat(i, 1)});
    end
    rd(8'h12, v); chk("R7 read wraps to byte 0", v, {24'h0, pat(0, 1)});
    // R12 holds after strobe
    @(negedge clk); chk("R12 hold", reg_rdata, {24'h0, pat(0, 1)});
    rd(8'h11, v); chk("R6 ptr after read", v, 32'h1);

    // R8 gating
    wr(8'h11, 32'h5);
    wr(8'h10, 32'h0000_0082);
    wr(8'h12, 32'h0000_0077);
    rd(8'h12, v); chk("R8 gated read zero", v, 32'h0);
    rd(8'h11, v); chk("R8 ptr unmoved", v, 32'h5);
    wr(8'h10, 32'h0000_008C);
    rd(8'h12, v); chk("R8 memory unchanged", v, {24'h0, pat(5, 1)});

    // R13 both strobes: write only
    rd(8'h18, v);
    wr(8'h11, 32'h7);
    @(negedge clk);
    reg_addr = 8'h12; reg_wdata = 32'h0000_00E1; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R13 rdata kept", reg_rdata, ID_EXP);
    rd(8'h11, v); chk("R13 single step", v, 32'h8);
    wr(8'h11, 32'h7);
    rd(8'h12, v); chk("R13 write stored", v, 32'h0000_00E1);

    // R9 identification
    rd(8'h18, v); chk("R9 id", v, ID_EXP);

    // R10 clock delay
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h05, v); chk("R10 dly all ones", v, 32'h33);
    wr(8'h05, 32'h0000_0021);
    rd(8'h05, v); chk("R10 dly pattern", v, 32'h21);

    // R11 mailbox
    wr(8'h15, 32'hDEAD_BEEF);
    rd(8'h15, v); chk("R11 mbox", v, 32'hDEAD_BEEF);
    wr(8'h15, 32'h1234_5678);
    rd(8'h15, v); chk("R11 mbox rewrite", v, 32'h1234_5678);

    // R12 unmapped offsets
    rd(8'h00, v); chk("R12 unmapped 00", v, 32'h0);
    wr(8'h13, 32'hFFFF_FFFF);
    rd(8'h13, v); chk("R12 unmapped 13", v, 32'h0);
    rd(8'hFF, v); chk("R12 unmapped FF", v, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule